// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block sits between a synchronous host and an external 1M x 16 pseudo-static RAM that has an asynchronous interface. The host places a single-word request: a read/write flag, a 20-bit word address, 16-bit write data and a 2-bit lane mask. The controller then produces a timed strobe sequence on the memory pins and pulses `req_ready` for one cycle when the request is finished. Every access walks the same four-phase sequence: idle, setup, strobe, hold. Address, chip selects and lane enables settle one cycle before the read or write strobe falls. They stay put for one cycle after the strobe rises.

The strobe length comes from two parameters, the memory access time and the clock period, both in picoseconds. It is the access time divided by the clock period, rounded up. With the defaults (70 ns, 10 ns) it is 7 cycles. The controller drives the shared data bus only for writes. Lanes that the host did not request come back as zero in read data. A request with an empty lane mask finishes at once and touches no memory pin.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_ub_n`=1, `mem_lb_n`=1, `mem_dq_oe`=0 and `req_ready`=0.
- R2: The two chip selects always hold opposite levels. The memory is selected (`mem_ce_n`=0 with `mem_ce2`=1) whenever `mem_oe_n` or `mem_we_n` is low.
- R3: A read holds `mem_oe_n` low and `mem_we_n` high for exactly the access count of cycles. `rsp_rdata` carries the memory data present on `mem_dq_in` in the last strobe cycle.
- R4: During an access, `mem_lb_n` is low exactly when lane mask bit 0 is set, and `mem_ub_n` is low exactly when bit 1 is set. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R5: Whenever the memory is deselected, both lane enables are high and both strobes are high (standby).
- R6: A write holds `mem_we_n` low and `mem_oe_n` high for exactly the access count of cycles. `mem_dq_oe` is high for the whole strobe, and `mem_dq_out` carries the host write data.
- R7: Select, address and lane enables are valid one cycle before a strobe falls and one cycle after it rises. They do not change while the memory stays selected.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. It is also low in the cycle before `mem_oe_n` falls.
- R9: In `rsp_rdata`, any lane whose mask bit was clear reads as zero.
- R10: `req_ready` is high for one cycle only. An accepted access raises it on the access count + 3 rising edges after the request is first sampled. A request seen while `req_ready` is high is not accepted in that cycle.
- R11: A request with lane mask 2'b00 raises `req_ready` after one edge with `rsp_rdata`=0, and selects no memory cycle.
- R12: The access count is ceil(access time / clock period): 7 cycles for 70 ns at 10 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 20 | Memory word address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Second chip select, active high |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable (write strobe), active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
Two functions can land in the same cycle. The completion pulse of one access can coincide with a host request that is still asserted, and the bus release after a write can meet the read strobe of the next access. The bench holds `req_valid` high across a completion and checks that the second pulse arrives one cycle later than normal. It also issues reads right after writes while a per-cycle monitor watches for `mem_dq_oe` high during or just before a low `mem_oe_n`. A responder model returns valid data only after the full access count, and drives junk on disabled lanes, so a short strobe or a missing lane mask shows up in the read data.

// File: rtl/psram_pkg.sv
// Package: shared types for the pseudo-static RAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package psram_pkg;

    // Phase of one memory access.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } psram_phase_t;

    localparam int unsigned ADDR_W = 20;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANES  = DATA_W / 8;

endpackage

// File: rtl/psram_timer.sv
// Module: psram_timer
// Counts the strobe phase. A load sets the count to LIMIT-1. The count
// then falls by one each cycle and stops at zero, where 'last' is high.
// Assumes: LIMIT >= 1; load is a single-cycle pulse.
module psram_timer #(
    parameter int unsigned LIMIT = 7,
    localparam int unsigned CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(LIMIT - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal flag for the sequencer.
    always_comb begin
        last = (cnt_q == '0);
    end

    // R12: the counter never goes above the computed access count.
    assert_cnt_in_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/psram_seq.sv
// Module: psram_seq
// Phase sequencer. Accepts a host request in idle, then steps through
// setup, strobe and hold. All memory control outputs are registered
// from the next phase, so the pins change glitch-free on the clock edge.
// Assumes: host holds req_valid until req_ready, then drops it or
// presents a new request. A request seen while ready is high is ignored.
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned ACC_CYC = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_be,
    output logic       accept,
    output logic       null_done,
    output logic       sample,
    output logic       sel_nxt,
    output logic       sel_q,
    output logic       rd_strb_q,
    output logic       wr_strb_q,
    output logic       drive_q,
    output logic       ready_q
);

    psram_phase_t ph_q, ph_n;
    logic         wr_q, wr_n;
    logic         tmr_load, tmr_last;

    psram_timer #(.LIMIT(ACC_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .last  (tmr_last)
    );

    // Next-phase decision and single-cycle event strobes.
    always_comb begin
        ph_n      = ph_q;
        accept    = 1'b0;
        null_done = 1'b0;
        sample    = 1'b0;
        tmr_load  = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req_valid && !ready_q) begin
                    if (req_be == 2'b00) begin
                        null_done = 1'b1;
                    end else begin
                        accept = 1'b1;
                        ph_n   = PH_SETUP;
                    end
                end
            end
            PH_SETUP: begin
                tmr_load = 1'b1;
                ph_n     = PH_STROBE;
            end
            PH_STROBE: begin
                if (tmr_last) begin
                    sample = !wr_q;
                    ph_n   = PH_HOLD;
                end
            end
            PH_HOLD: begin
                ph_n = PH_IDLE;
            end
            default: ph_n = PH_IDLE;
        endcase
        wr_n    = accept ? req_write : wr_q;
        sel_nxt = (ph_n != PH_IDLE);
    end

    // Phase, direction and registered pin controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            wr_q      <= 1'b0;
            sel_q     <= 1'b0;
            rd_strb_q <= 1'b0;
            wr_strb_q <= 1'b0;
            drive_q   <= 1'b0;
            ready_q   <= 1'b0;
        end else begin
            ph_q      <= ph_n;
            wr_q      <= wr_n;
            sel_q     <= sel_nxt;
            rd_strb_q <= (ph_n == PH_STROBE) && !wr_n;
            wr_strb_q <= (ph_n == PH_STROBE) && wr_n;
            drive_q   <= sel_nxt && wr_n;
            ready_q   <= null_done || (ph_q == PH_HOLD);
        end
    end

    // R3/R6: the read and write strobes never overlap.
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strb_q && wr_strb_q));

    // R10: the completion pulse lasts one cycle.
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q);

    // R7: a strobe starts only after a cycle of select (setup).
    assert_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strb_q || wr_strb_q) |-> $past(sel_q));

    // R7: select survives the cycle after the strobe ends (hold).
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strb_q || wr_strb_q) |-> sel_q);

    // R11: an empty-mask request never starts a memory cycle.
    assert_null_no_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        null_done |=> !sel_q);

endmodule

// File: rtl/psram_datapath.sv
// Module: psram_datapath
// Holds the accepted address, write data and lane mask. Drives the
// registered lane enables, and captures read data with unrequested
// lanes forced to zero.
// Assumes: accept, sample and null_done come from psram_seq and are
// never high in the same cycle.
module psram_datapath
    import psram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              null_done,
    input  logic              sample,
    input  logic              sel_nxt,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  lane_n_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [LANES-1:0]  be_q, be_nxt;
    logic [DATA_W-1:0] lane_mask;

    // Widen each lane bit to a byte-wide mask.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    // Mask that applies from the next cycle.
    always_comb begin
        be_nxt = accept ? req_be : be_q;
    end

    // Latch the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Registered lane enables: all high (standby) outside an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_n_q <= '1;
        end else begin
            lane_n_q <= sel_nxt ? ~be_nxt : '1;
        end
    end

    // Capture read data at the end of the strobe, or zero on an empty-mask request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (null_done) begin
            rdata_q <= '0;
        end else if (sample) begin
            rdata_q <= mem_dq_in & lane_mask;
        end
    end

    // R9: a lane whose mask bit is clear reads as zero after a capture.
    assert_masked_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> ((rdata_q & ~lane_mask) == '0));

    // R7: the address stays put while an access holds the lanes enabled.
    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_n_q != '1) && $past(lane_n_q != '1) |-> $stable(addr_q));

endmodule

// File: rtl/psram_ctrl.sv
// Module: psram_ctrl (top)
// Synchronous host front-end for a 1M x 16 asynchronous pseudo-static
// RAM. Works out the strobe length from the access time and the clock
// period, then wires the sequencer and datapath onto the memory pins.
// Assumes: one outstanding request. The external bus is resolved
// outside, using mem_dq_oe as the drive enable.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned T_ACC_PS = 70000,
    parameter int unsigned CLK_PS   = 10000,
    localparam int unsigned ACC_CYC_RAW = (T_ACC_PS + CLK_PS - 1) / CLK_PS,
    localparam int unsigned ACC_CYC     = (ACC_CYC_RAW < 1) ? 1 : ACC_CYC_RAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    logic             accept, null_done, sample, sel_nxt;
    logic             sel_q, rd_strb_q, wr_strb_q, drive_q, ready_q;
    logic [LANES-1:0] lane_n_q;

    psram_seq #(.ACC_CYC(ACC_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_be    (req_be),
        .accept    (accept),
        .null_done (null_done),
        .sample    (sample),
        .sel_nxt   (sel_nxt),
        .sel_q     (sel_q),
        .rd_strb_q (rd_strb_q),
        .wr_strb_q (wr_strb_q),
        .drive_q   (drive_q),
        .ready_q   (ready_q)
    );

    psram_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .null_done (null_done),
        .sample    (sample),
        .sel_nxt   (sel_nxt),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .lane_n_q  (lane_n_q),
        .rdata_q   (rsp_rdata)
    );

    // Pin mapping: select drives both polarities; strobes are active low.
    always_comb begin
        mem_ce_n  = !sel_q;
        mem_ce2   = sel_q;
        mem_oe_n  = !rd_strb_q;
        mem_we_n  = !wr_strb_q;
        mem_lb_n  = lane_n_q[0];
        mem_ub_n  = lane_n_q[1];
        mem_dq_oe = drive_q;
        req_ready = ready_q;
    end

    // R8: the controller never drives the bus while the memory may drive it.
    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R8: drive is released at least one cycle before a read strobe falls.
    assert_release_before_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R5: when deselected, the device is in standby with no strobe.
    assert_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_ub_n && mem_lb_n && mem_oe_n && mem_we_n));

    // R6: the bus is driven throughout every write strobe.
    assert_write_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R2: both chip selects agree on selection.
    assert_select_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n != mem_ce2);

endmodule

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;

    localparam int CLK_PS = 10000;
    localparam int ACC_PS = 70000;
    localparam int N      = (ACC_PS + CLK_PS - 1) / CLK_PS;   // R12: expected 7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    psram_ctrl #(.T_ACC_PS(ACC_PS), .CLK_PS(CLK_PS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h0101) ^ 16'h5A3C;
    endfunction

    // ---------------- memory responder ----------------
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    int  rdcnt;
    wire sel = !mem_ce_n && mem_ce2;
    wire [7:0] ma = mem_addr[7:0];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
            rdcnt <= 0;
        end else begin
            if (sel && !mem_oe_n && mem_we_n) rdcnt <= rdcnt + 1;
            else rdcnt <= 0;
            if (sel && !mem_we_n) begin
                if (!mem_lb_n) mem[ma][7:0]  <= mem_dq_out[7:0];
                if (!mem_ub_n) mem[ma][15:8] <= mem_dq_out[15:8];
            end
        end
    end

    assign mem_dq_in = (sel && !mem_oe_n && mem_we_n && rdcnt >= N - 1) ?
                       {mem_ub_n ? 8'hC3 : mem[ma][15:8], mem_lb_n ? 8'h3C : mem[ma][7:0]} :
                       16'hBEEF;

    // ---------------- per-cycle monitor ----------------
    int v_r2 = 0, v_r3 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r10 = 0;
    int oe_run = 0, we_run = 0, last_oe_w = 0, last_we_w = 0, ncyc = 0;
    logic [19:0] last_addr = '0;
    logic [1:0]  last_lanes = 2'b11;
    logic        p_sel = 0, p_strb = 0, p_oe_n = 1, p_dq_oe = 0, p_ready = 0;
    logic [19:0] p_addr = '0;
    logic [1:0]  p_lanes = 2'b11;

    always @(negedge clk) begin
        if (rst_n) begin
            logic strb;
            strb = !mem_oe_n || !mem_we_n;
            if (mem_ce_n == mem_ce2) v_r2++;                        // R2
            if (strb && !sel) v_r2++;
            if (!sel && !(mem_ub_n && mem_lb_n && !strb)) v_r5++;   // R5
            if (!mem_oe_n && !mem_we_n) v_r3++;
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                last_oe_w = oe_run;
                if (oe_run != N) v_r3++;                            // R3
                oe_run = 0;
            end
            if (!mem_we_n) begin
                we_run++;
                if (!mem_dq_oe) v_r6++;                             // R6
            end else if (we_run != 0) begin
                last_we_w = we_run;
                if (we_run != N) v_r6++;
                we_run = 0;
            end
            if (strb && !p_strb && !p_sel) v_r7++;                  // R7 setup
            if (!strb && p_strb && !sel) v_r7++;                    // R7 hold
            if (sel && p_sel && (mem_addr != p_addr || {mem_ub_n, mem_lb_n} != p_lanes)) v_r7++;
            if (mem_dq_oe && !mem_oe_n) v_r8++;                     // R8
            if (!mem_oe_n && p_oe_n && p_dq_oe) v_r8++;
            if (req_ready && p_ready) v_r10++;                      // R10
            if (sel && !p_sel) ncyc++;
            if (strb) begin
                last_addr  = mem_addr;
                last_lanes = {mem_ub_n, mem_lb_n};
            end
            p_sel = sel; p_strb = strb; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
            p_ready = req_ready; p_addr = mem_addr; p_lanes = {mem_ub_n, mem_lb_n};
        end
    end

    // ---------------- host transactions ----------------
    task automatic txn(input bit wr, input logic [19:0] a, input logic [15:0] wd,
                       input logic [1:0] be, output logic [15:0] rd, output int lat);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!req_ready && lat < 100);
        rd = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] lanes16(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] addrs [5];
        logic [15:0] rd, exp, wd;
        int lat, n0;
        addrs = '{20'h00000, 20'hFFFFF, 20'hA5A5A, 20'h5A5A5, 20'h12301};
        for (int i = 0; i < 256; i++) shadow[i] = init_word(i);

        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 8'b10111100,
              "R1 pins in reset", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 8'b10111100);
        rst_n = 1'b1;
        @(negedge clk);
        check({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 8'b10111100,
              "R1 pins after reset", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 8'b10111100);

        for (int ai = 0; ai < 5; ai++) begin
            logic [19:0] a;
            logic [7:0]  k;
            a = addrs[ai];
            k = a[7:0];
            // R3: read of preset content
            txn(1'b0, a, 16'h0, 2'b11, rd, lat);
            check(rd == shadow[k], "R3 read data", rd, shadow[k]);
            check(lat == N + 3, "R10 read latency", lat, N + 3);
            check(last_addr == a, "R7 address on pins", last_addr, a);
            for (int wb = 1; wb < 4; wb++) begin
                wd = 16'(a[15:0] * 16'd37 + wb * 16'h1111) ^ 16'h9C6B;
                txn(1'b1, a, wd, 2'(wb), rd, lat);
                check(lat == N + 3, "R6 write latency", lat, N + 3);
                check(last_lanes == ~2'(wb), "R4 write lanes", last_lanes, ~2'(wb));
                check(last_we_w == N, "R6 write strobe width", last_we_w, N);
                shadow[k] = (shadow[k] & ~lanes16(2'(wb))) | (wd & lanes16(2'(wb)));
                for (int rb = 0; rb < 4; rb++) begin
                    n0 = ncyc;
                    txn(1'b0, a, 16'h0, 2'(rb), rd, lat);
                    exp = shadow[k] & lanes16(2'(rb));
                    if (rb == 0) begin
                        check(rd == 16'h0, "R11 empty mask data", rd, 0);
                        check(lat == 1, "R11 empty mask latency", lat, 1);
                        check(ncyc == n0, "R11 no memory cycle", ncyc - n0, 0);
                    end else begin
                        check(rd == exp, "R9 masked read data", rd, exp);
                        check(last_lanes == ~2'(rb), "R4 read lanes", last_lanes, ~2'(rb));
                        check(last_oe_w == N, "R3 read strobe width", last_oe_w, N);
                    end
                end
            end
        end

        // R10: request held through completion; second access starts one cycle later
        begin
            int gap;
            req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00033; req_wdata = 16'h7E81; req_be = 2'b11;
            while (!req_ready) @(negedge clk);
            gap = 0;
            do begin
                @(posedge clk); gap++;
                @(negedge clk);
            end while (!req_ready && gap < 100);
            req_valid = 1'b0;
            @(negedge clk);
            check(gap == N + 4, "R10 request ignored during ready", gap, N + 4);
            shadow[8'h33] = 16'h7E81;
            txn(1'b0, 20'h00033, 16'h0, 2'b11, rd, lat);
            check(rd == 16'h7E81, "R3 read after back-to-back write", rd, 16'h7E81);
        end

        check(last_oe_w == N && N == 7, "R12 access count", last_oe_w, 7);
        check(v_r2 == 0, "R2 select violations", v_r2, 0);
        check(v_r3 == 0, "R3 read strobe violations", v_r3, 0);
        check(v_r5 == 0, "R5 standby violations", v_r5, 0);
        check(v_r6 == 0, "R6 write strobe violations", v_r6, 0);
        check(v_r7 == 0, "R7 setup/hold violations", v_r7, 0);
        check(v_r8 == 0, "R8 bus contention violations", v_r8, 0);
        check(v_r10 == 0, "R10 ready width violations", v_r10, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule